// File: doc/BRIEF.md
# Indirect Bus Register Access Unit

This block lets an 8-bit host bus reach a 64 KiB internal address space through four directly addressed byte locations: a settings byte, two pointer bytes and a data window. The host loads the pointer through the two pointer bytes and then moves data through the window. Each completed window write becomes one internal write strobe at the pointer. Each window read becomes one internal read strobe, and the returned byte appears on the host data bus.

The settings byte has three controls. One turns window access on. One picks which pointer byte holds the upper half of the address. One makes the pointer step forward after every completed window access, so the host can stream a block of bytes without reloading the address. The host strobes (`cs_n`, `rd_n`, `wr_n`) are sampled on `clk`. A read must stay active for at least four clock cycles before its data is used. Every access must be separated from the next by at least one clock cycle with its strobe inactive.

Top module: `ind_bus_window`

## Requirements
- R1: After reset the settings byte reads 0x00, both pointer bytes read 0x00, and no internal strobe is issued until the host accesses the window.
- R2: Host offset 0 is the settings byte. Bit 7 enables the window, bit 1 selects byte order and bit 0 enables stepping. Writing 0xFF reads back 0x83, because all other bits read as zero.
- R3: With bit 1 clear, offset 1 holds pointer bits 15:8 and offset 2 holds bits 7:0. With bit 1 set, offset 1 holds bits 7:0 and offset 2 holds bits 15:8. This applies to both reads and writes.
- R4: With the window enabled, a write to offset 3 produces exactly one `mem_we` pulse carrying the pointer and the written byte. The pulse comes in the cycle after the write strobe is released.
- R5: With the window enabled, a read of offset 3 produces exactly one `mem_re` pulse at the pointer. The byte the memory returns one cycle later is driven on `rdata` while the read is held.
- R6: With bit 0 set, the pointer advances by one after each completed window access, read or write. With bit 0 clear, the pointer is unchanged.
- R7: Advancing from 0xFFFF gives 0x0000.
- R8: With the window disabled, offset-3 accesses issue neither `mem_we` nor `mem_re`. Such reads return 0x00 and the pointer does not move.
- R9: Reading a pointer byte returns the current pointer, including any step already taken.
- R10: If a window write is released in the same cycle as a window read begins, the write goes to the old pointer and the read uses the stepped pointer. `mem_we` and `mem_re` are never high in the same cycle.
- R11: A window access steps the pointer exactly once, however many cycles its strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 2 | Host byte offset (0 settings, 1 and 2 pointer, 3 window) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| mem_addr | output | 16 | Internal memory address (the pointer) |
| mem_wdata | output | 8 | Internal memory write data |
| mem_we | output | 1 | Internal write strobe, one cycle |
| mem_re | output | 1 | Internal read strobe, one cycle |
| mem_rdata | input | 8 | Internal memory read data, valid one cycle after `mem_re` |

## Verification
A window write being released and a window read beginning can land in the same cycle. In that cycle the pointer step and the memory read both want the pointer. The bench provokes this by raising `wr_n` and lowering `rd_n` on the same clock edge with chip select held low. It then checks three things: the logged write address is the old pointer, the logged read address and returned byte belong to the stepped pointer, and a monitor counts zero cycles with both strobes high.

// File: rtl/ind_bus_window.sv
module ind_bus_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata
);
  localparam logic [1:0] OFS_SET = 2'd0;
  localparam logic [1:0] OFS_PA  = 2'd1;
  localparam logic [1:0] OFS_PB  = 2'd2;
  localparam logic [1:0] OFS_WIN = 2'd3;

  logic        rd_q, wr_q, re_go, re_q;
  logic [1:0]  a_lat;
  logic [7:0]  wd_lat, rd_buf, opt;
  logic [15:0] ptr;

  wire rd_act   = ~cs_n & ~rd_n;
  wire wr_act   = ~cs_n & ~wr_n;
  wire rd_start = rd_act & ~rd_q;
  wire rd_end   = ~rd_act & rd_q;
  wire wr_start = wr_act & ~wr_q;
  wire wr_end   = ~wr_act & wr_q;

  wire en   = opt[7];
  wire swap = opt[1];
  wire step = opt[0];

  wire win_wr  = wr_end & (a_lat == OFS_WIN) & en;
  wire win_rd  = rd_end & (a_lat == OFS_WIN) & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      re_go  <= 1'b0;
      re_q   <= 1'b0;
      a_lat  <= OFS_SET;
      wd_lat <= 8'h00;
      rd_buf <= 8'h00;
      opt    <= 8'h00;
      ptr    <= 16'h0000;
    end else begin
      rd_q  <= rd_act;
      wr_q  <= wr_act;
      re_go <= rd_start & (addr == OFS_WIN) & en;
      re_q  <= re_go;
      if (rd_start | wr_start) a_lat <= addr;
      if (wr_act) wd_lat <= wdata;
      if (re_q) rd_buf <= mem_rdata;
      if (wr_end) begin
        case (a_lat)
          OFS_SET: opt <= {wd_lat[7], 5'b00000, wd_lat[1:0]};
          OFS_PA:  if (swap) ptr[7:0] <= wd_lat; else ptr[15:8] <= wd_lat;
          OFS_PB:  if (swap) ptr[15:8] <= wd_lat; else ptr[7:0] <= wd_lat;
          default: ;
        endcase
      end
      if ((win_wr | win_rd) & step) ptr <= ptr + 16'd1;
    end
  end

  always_comb begin
    case (a_lat)
      OFS_SET: rdata = opt;
      OFS_PA:  rdata = swap ? ptr[7:0]  : ptr[15:8];
      OFS_PB:  rdata = swap ? ptr[15:8] : ptr[7:0];
      default: rdata = en ? rd_buf : 8'h00;
    endcase
  end

  assign mem_addr  = ptr;
  assign mem_wdata = wd_lat;
  assign mem_we    = win_wr;
  assign mem_re    = re_go;
endmodule

// File: rtl/ind_bus_window_chk.sv
module ind_bus_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  opt
);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !opt[7] |-> !mem_we && !mem_re);
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_re_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && opt[0] |=> mem_addr == $past(mem_addr) + 16'd1);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !opt[0] |=> $stable(mem_addr));
  p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> $stable(mem_addr));
endmodule

bind ind_bus_window ind_bus_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .opt(opt)
);

// File: tb/sim_ind_bus_window.sv
module sim_ind_bus_window;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata, mem_wdata, mem_rdata = 8'h00;
  logic [15:0] mem_addr;
  logic mem_we, mem_re;
  int checks = 0, fails = 0;
  int wr_cnt = 0, re_cnt = 0, both_cnt = 0;
  logic [15:0] last_wa = 16'h0, last_ra = 16'h0;
  logic [7:0] last_wd = 8'h0;
  bit done = 0;

  always #5 clk = ~clk;

  ind_bus_window u0 (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .addr, .wdata, .rdata,
    .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata);

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin wr_cnt++; last_wa = mem_addr; last_wd = mem_wdata; end
    if (mem_re) begin re_cnt++; last_ra = mem_addr; mem_rdata <= pat(mem_addr); end
    if (mem_we && mem_re) both_cnt++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; addr = a; wdata = d; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1; cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, input int hold = 4);
    @(negedge clk); cs_n = 0; addr = a; rd_n = 0;
    repeat (hold) @(negedge clk);
    d = rdata; rd_n = 1; cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [15:0] p, input bit swapped);
    bus_wr(2'd1, swapped ? p[7:0] : p[15:8]);
    bus_wr(2'd2, swapped ? p[15:8] : p[7:0]);
  endtask

  task automatic get_ptr(output logic [15:0] p, input bit swapped);
    logic [7:0] b1, b2;
    bus_rd(2'd1, b1); bus_rd(2'd2, b2);
    p = swapped ? {b2, b1} : {b1, b2};
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] p;
    bus_rd(2'd0, d); chk("R1 settings", d, 8'h00);
    get_ptr(p, 0); chk("R1 pointer", p, 16'h0000);
    chk("R1 no strobes", wr_cnt + re_cnt, 0);
  endtask

  task automatic t_settings;
    logic [7:0] d;
    bus_wr(2'd0, 8'hFF); bus_rd(2'd0, d); chk("R2 readback", d, 8'h83);
    bus_wr(2'd0, 8'h7C); bus_rd(2'd0, d); chk("R2 unused bits", d, 8'h00);
  endtask

  task automatic t_order;
    logic [7:0] d;
    bus_wr(2'd0, 8'h80); set_ptr(16'h1234, 0);
    bus_wr(2'd3, 8'hAB);
    chk("R3 order0 addr", last_wa, 16'h1234); chk("R4 data", last_wd, 8'hAB);
    chk("R4 one pulse", wr_cnt, 1);
    bus_wr(2'd0, 8'h82);
    bus_rd(2'd1, d); chk("R3 order1 off1 low", d, 8'h34);
    bus_rd(2'd2, d); chk("R3 order1 off2 high", d, 8'h12);
    bus_wr(2'd1, 8'h56); bus_wr(2'd3, 8'h11);
    chk("R3 order1 write low", last_wa, 16'h1256);
  endtask

  task automatic t_read;
    logic [7:0] d; logic [15:0] p; int r0;
    bus_wr(2'd0, 8'h80); set_ptr(16'hA55A, 0); r0 = re_cnt;
    bus_rd(2'd3, d);
    chk("R5 data", d, pat(16'hA55A)); chk("R5 addr", last_ra, 16'hA55A);
    chk("R5 one pulse", re_cnt - r0, 1);
    get_ptr(p, 0); chk("R6 no step", p, 16'hA55A);
  endtask

  task automatic t_step;
    logic [7:0] d; logic [15:0] p;
    bus_wr(2'd0, 8'h81); set_ptr(16'h0100, 0);
    bus_wr(2'd3, 8'h01); chk("R6 w0", last_wa, 16'h0100);
    bus_wr(2'd3, 8'h02); chk("R6 w1", last_wa, 16'h0101);
    bus_rd(2'd3, d); chk("R6 read addr", last_ra, 16'h0102);
    chk("R6 read data", d, pat(16'h0102));
    bus_rd(2'd2, d); chk("R9 stepped low byte", d, 8'h03);
  endtask

  task automatic t_wrap;
    logic [7:0] d; logic [15:0] p;
    bus_wr(2'd0, 8'h81); set_ptr(16'hFFFF, 0);
    bus_rd(2'd3, d); chk("R7 data at top", d, pat(16'hFFFF));
    get_ptr(p, 0); chk("R7 wrapped", p, 16'h0000);
  endtask

  task automatic t_disabled;
    logic [7:0] d; logic [15:0] p; int w0, r0;
    bus_wr(2'd0, 8'h01); set_ptr(16'h2222, 0);
    w0 = wr_cnt; r0 = re_cnt;
    bus_wr(2'd3, 8'h99); bus_rd(2'd3, d);
    chk("R8 read zero", d, 8'h00);
    chk("R8 no we", wr_cnt - w0, 0); chk("R8 no re", re_cnt - r0, 0);
    get_ptr(p, 0); chk("R8 pointer held", p, 16'h2222);
  endtask

  task automatic t_long;
    logic [7:0] d; logic [15:0] p; int r0;
    bus_wr(2'd0, 8'h81); set_ptr(16'h0040, 0); r0 = re_cnt;
    bus_rd(2'd3, d, 12);
    chk("R11 data", d, pat(16'h0040)); chk("R11 one re", re_cnt - r0, 1);
    get_ptr(p, 0); chk("R11 single step", p, 16'h0041);
  endtask

  task automatic t_overlap;
    logic [7:0] d; logic [15:0] p;
    bus_wr(2'd0, 8'h81); set_ptr(16'h3000, 0);
    @(negedge clk); cs_n = 0; addr = 2'd3; wdata = 8'h5E; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1; rd_n = 0;
    repeat (4) @(negedge clk);
    d = rdata; rd_n = 1; cs_n = 1;
    repeat (2) @(negedge clk);
    chk("R10 write old addr", last_wa, 16'h3000);
    chk("R10 read new addr", last_ra, 16'h3001);
    chk("R10 read data", d, pat(16'h3001));
    chk("R10 no overlap", both_cnt, 0);
    get_ptr(p, 0); chk("R10 two steps", p, 16'h3002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_settings; t_order; t_read; t_step;
    t_wrap; t_disabled; t_long; t_overlap;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule